// File: doc/BRIEF.md
# Serial Configuration Port with Frame-Length Checking

This block is a slave on a four-wire synchronous serial link: a low-active select, a serial clock, a data input and a data output. Every transaction is a 16-bit word. The top three bits pick one of eight 12-bit configuration registers. The next bit says whether the low twelve bits are written. A write is committed when the select returns high, and only if the frame held exactly sixteen rising clock edges. A frame of any other length is thrown away and raises a sticky framing-error flag.

While the host shifts its word in, the block shifts a word out, MSB first. By default this is a status word. It holds the framing flag, a power-up flag and one sticky latch for each level fault input. A mask register can block any of these latches. When the frame is a read (write bit 0), the last twelve output bits carry the addressed register instead. The register contents go out in parallel to the core, and bit 0 of register 7 is the run enable. All serial inputs are resynchronised to the system clock. Because of this, each serial clock phase must last at least three system clock cycles.

Top module: `spi_cfg_port`

## Requirements
- R1: A frame with exactly 16 rising serial-clock edges and bit 12 = 1 writes bits 11:0 into the register selected by bits 15:13 when the select rises. Register contents appear on `regs_o` at bits [12*a+11 : 12*a].
- R2: A frame with fewer or more than 16 rising edges changes no register, leaves the fault latches as they are, and sets status bit 15 (framing error).
- R3: A committed write clears the whole status word: the framing flag, the power-up flag and all fault latches.
- R4: The first output bit is status bit 15, and it is valid before the first rising edge of the frame. The following bits are sent MSB first, and each one is launched on a falling serial-clock edge.
- R5: A frame with bit 12 = 0 changes no register and does not clear the status. Its output bits 11:0 carry the register selected by its bits 15:13. Its output bits 15:12 are still status bits 15:12.
- R6: The status word is {framing flag, power-up flag, 2'b00, fault latches[11:0]}. It is the output word of every frame that is not a read.
- R7: Fault latch i sets when fault_i[i] is high and bit i of register 6 (mask) is 0. It stays set until a committed write. A masked fault is ignored.
- R8: After reset, all registers are zero, run_o is 0, the framing flag is 0 and the power-up flag is 1. run_o follows bit 0 of register 7.
- R9: While the select is high, serial clock and data activity has no effect, and miso_oe_o is 0. While the select is low, miso_oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data into the block |
| fault_i | input | 12 | Level fault inputs, synchronous to clk |
| miso_o | output | 1 | Serial data out of the block |
| miso_oe_o | output | 1 | Output enable for miso_o |
| run_o | output | 1 | Run enable (register 7 bit 0) |
| regs_o | output | 96 | All eight registers, register a at bits [12*a+11 : 12*a] |

## Verification
A broken edge counter shows up when the frame ends. A wrongly accepted short or long frame changes `regs_o`, and a wrongly rejected exact frame leaves it unchanged. Either case also flips the framing bit, which the bench reads as the first bit of the next frame. A stale or wrongly loaded transmit register shows in the sampled serial word of the same frame, within one serial clock phase of the bad bit. A fault latch that misbehaves shows at the next write frame, where the whole status word is compared.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int FRAME_W   = 16;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 12;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int MASK_ADDR = 6;
  localparam int CTRL_ADDR = 7;
  localparam int SYNC_LEN  = 2;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= IDLE;
    else     chain[0] <= din;
  end

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[k] <= IDLE;
        else     chain[k] <= chain[k-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int FRAME_W = 16,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              start,
  input  logic              stop,
  input  logic              sclk_rise,
  input  logic              mosi,
  output logic              commit_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              peek_o,
  output logic [ADDR_W-1:0] peek_addr_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_PEEK = CNT_W'(ADDR_W);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      sh          <= '0;
      commit_o    <= 1'b0;
      err_o       <= 1'b0;
      addr_o      <= '0;
      data_o      <= '0;
      peek_o      <= 1'b0;
      peek_addr_o <= '0;
    end else begin
      commit_o <= 1'b0;
      err_o    <= 1'b0;
      peek_o   <= 1'b0;
      if (start) begin
        cnt <= '0;
      end else if (active && sclk_rise) begin
        sh <= {sh[FRAME_W-2:0], mosi};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        // the 4th rising edge carries the write flag; address is already in sh
        if (cnt == CNT_PEEK && !mosi) begin
          peek_o      <= 1'b1;
          peek_addr_o <= sh[ADDR_W-1:0];
        end
      end
      if (stop) begin
        if (cnt == CNT_FULL) begin
          commit_o <= sh[DATA_W];
          addr_o   <= sh[FRAME_W-1 -: ADDR_W];
          data_o   <= sh[DATA_W-1:0];
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

  // R2
  count_sat_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_MAX);
  // R1
  commit_err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(commit_o && err_o));
  // R2
  err_after_stop_chk: assert property (@(posedge clk) disable iff (rst) stop |=> (commit_o || err_o || !$past(cnt == CNT_FULL) || !$past(sh[DATA_W])) );
endmodule

// File: rtl/spi_diag.sv
module spi_diag #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  fault_i,
  input  logic [DATA_W-1:0]  mask_i,
  input  logic               clr_i,
  input  logic               err_i,
  output logic [FRAME_W-1:0] status_o
);
  localparam int PAD = FRAME_W - 2 - DATA_W;

  logic              frm_err;
  logic              pwr_up;
  logic [DATA_W-1:0] flt;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_err <= 1'b0;
      pwr_up  <= 1'b1;
      flt     <= '0;
    end else if (clr_i) begin
      frm_err <= 1'b0;
      pwr_up  <= 1'b0;
      flt     <= '0;
    end else begin
      if (err_i) frm_err <= 1'b1;
      flt <= flt | (fault_i & ~mask_i);
    end
  end

  assign status_o = {frm_err, pwr_up, {PAD{1'b0}}, flt};

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (rst) clr_i |=> (status_o[FRAME_W-1 -: 2] == 2'b00));
  // R2
  err_sets_flag_chk: assert property (@(posedge clk) disable iff (rst) err_i |=> status_o[FRAME_W-1]);
  // R7
  sticky_latch_chk: assert property (@(posedge clk) disable iff (rst) !clr_i |=> ((flt & $past(flt)) == $past(flt)));
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst) !clr_i |=> ((flt & ~$past(flt) & $past(mask_i)) == '0));
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               sclk_fall,
  input  logic [FRAME_W-1:0] status_i,
  input  logic               sub_i,
  input  logic [DATA_W-1:0]  sub_data_i,
  output logic               miso_o,
  output logic               oe_o
);
  localparam int SUB_MSB = FRAME_W - 2;

  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      oe_o <= 1'b0;
    end else if (!active) begin
      sh   <= status_i;
      oe_o <= 1'b0;
    end else begin
      oe_o <= 1'b1;
      if (sclk_fall)  sh <= {sh[FRAME_W-2:0], 1'b0};
      else if (sub_i) sh[SUB_MSB -: DATA_W] <= sub_data_i;
    end
  end

  assign miso_o = sh[FRAME_W-1];

  // R4
  hold_between_falls_chk: assert property (@(posedge clk) disable iff (rst) (active && !sclk_fall) |=> $stable(miso_o));
  // R9
  oe_follows_select_chk: assert property (@(posedge clk) disable iff (rst) !active |=> !oe_o);
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int P_FRAME_W = FRAME_W,
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_DATA_W  = DATA_W,
  parameter int P_SYNC    = SYNC_LEN
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              csn_i,
  input  logic                              sclk_i,
  input  logic                              mosi_i,
  input  logic [P_DATA_W-1:0]               fault_i,
  output logic                              miso_o,
  output logic                              miso_oe_o,
  output logic                              run_o,
  output logic [(1<<P_ADDR_W)*P_DATA_W-1:0] regs_o
);
  localparam int NREG = 1 << P_ADDR_W;

  logic [2:0] sync_q;
  logic [1:0] edge_prev;
  logic       csn_s, sclk_s, mosi_s;
  logic       sel_start, sel_stop, clk_rise, clk_fall;

  spi_in_sync #(.W(3), .STAGES(P_SYNC), .IDLE(3'b001)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({mosi_i, sclk_i, csn_i}),
    .q   (sync_q)
  );

  assign {mosi_s, sclk_s, csn_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) edge_prev <= 2'b01;
    else     edge_prev <= {sclk_s, csn_s};
  end

  assign sel_start = edge_prev[0] & ~csn_s;
  assign sel_stop  = ~edge_prev[0] & csn_s;
  assign clk_rise  = ~edge_prev[1] & sclk_s;
  assign clk_fall  = edge_prev[1] & ~sclk_s;

  logic                commit, frm_err, peek;
  logic [P_ADDR_W-1:0] wr_addr, peek_addr;
  logic [P_DATA_W-1:0] wr_data;

  spi_frame_rx #(.FRAME_W(P_FRAME_W), .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .active      (~csn_s),
    .start       (sel_start),
    .stop        (sel_stop),
    .sclk_rise   (clk_rise),
    .mosi        (mosi_s),
    .commit_o    (commit),
    .err_o       (frm_err),
    .addr_o      (wr_addr),
    .data_o      (wr_data),
    .peek_o      (peek),
    .peek_addr_o (peek_addr)
  );

  logic [P_DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (commit) begin
      regs[wr_addr] <= wr_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_flat
      assign regs_o[g*P_DATA_W +: P_DATA_W] = regs[g];
    end
  endgenerate

  assign run_o = regs[CTRL_ADDR][0];

  logic [P_FRAME_W-1:0] status;

  spi_diag #(.FRAME_W(P_FRAME_W), .DATA_W(P_DATA_W)) u_diag (
    .clk      (clk),
    .rst      (rst),
    .fault_i  (fault_i),
    .mask_i   (regs[MASK_ADDR]),
    .clr_i    (commit),
    .err_i    (frm_err),
    .status_o (status)
  );

  spi_tx #(.FRAME_W(P_FRAME_W), .DATA_W(P_DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .active     (~csn_s),
    .sclk_fall  (clk_fall),
    .status_i   (status),
    .sub_i      (peek),
    .sub_data_i (regs[peek_addr]),
    .miso_o     (miso_o),
    .oe_o       (miso_oe_o)
  );

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit && wr_addr == P_ADDR_W'(CTRL_ADDR)) |=> $stable(run_o));
  // R2
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst) !commit |=> $stable(regs_o));
endmodule

// File: tb/spi_cfg_port_test.sv
`timescale 1ns/1ps
module spi_cfg_port_test;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csn_i = 1'b1, sclk_i = 1'b0, mosi_i = 1'b0;
  logic [11:0] fault_i = '0;
  logic        miso_o, miso_oe_o, run_o;
  logic [95:0] regs_o;

  always #2.5 clk = ~clk;

  spi_cfg_port uut (
    .clk(clk), .rst(rst), .csn_i(csn_i), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .fault_i(fault_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .run_o(run_o), .regs_o(regs_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [11:0] m_regs [8];
  logic        m_ff, m_por;
  logic [11:0] m_flt;
  logic        oe_seen;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [95:0] exp_flat();
    logic [95:0] f;
    for (int a = 0; a < 8; a++) f[a*12 +: 12] = m_regs[a];
    return f;
  endfunction

  function automatic logic [15:0] exp_resp(input logic [15:0] w, input int n);
    logic [11:0] low;
    low = (n >= 4 && !w[12]) ? m_regs[w[15:13]] : m_flt;
    return {m_ff, m_por, 2'b00, low};
  endfunction

  function automatic logic [15:0] valid_mask(input int n);
    logic [15:0] m;
    m = '0;
    if (n == 0) m[15] = 1'b1;
    for (int i = 0; i < 16; i++) if (i < n) m[15-i] = 1'b1;
    return m;
  endfunction

  task automatic frame(input logic [15:0] w, input int n, output logic [15:0] rd);
    rd = '0;
    @(negedge clk) csn_i = 1'b0;
    if (n == 0) begin
      wait_clk(H);
      rd[15] = miso_o;
      oe_seen = miso_oe_o;
    end
    for (int i = 0; i < n; i++) begin
      mosi_i = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(H);
      if (i == 0) oe_seen = miso_oe_o;
      if (i < 16) rd[15-i] = miso_o;
      sclk_i = 1'b1;
      wait_clk(H);
      sclk_i = 1'b0;
    end
    wait_clk(H);
    csn_i = 1'b1;
    mosi_i = 1'b0;
    wait_clk(10);
  endtask

  task automatic do_frame(input string tag, input logic [15:0] w, input int n);
    logic [15:0] rd, exp, vm;
    exp = exp_resp(w, n);
    vm  = valid_mask(n);
    frame(w, n, rd);
    chk({tag, " R4 R6 serial word"}, rd & vm, exp & vm);
    chk("R9 oe while selected", oe_seen, 1'b1);
    if (n == 16 && w[12]) begin
      m_regs[w[15:13]] = w[11:0];
      m_ff = 1'b0; m_por = 1'b0; m_flt = '0;
    end else if (n != 16) begin
      m_ff = 1'b1;
    end
    chk({tag, " R1 R2 R5 registers"}, regs_o, exp_flat());
    chk({tag, " R8 run"}, run_o, m_regs[7][0]);
  endtask

  task automatic pulse_fault(input logic [11:0] pat);
    @(negedge clk) fault_i = pat;
    wait_clk(3);
    fault_i = '0;
    wait_clk(2);
    m_flt = m_flt | (pat & ~m_regs[6]);
  endtask

  initial begin
    wait_clk(150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4417));
    for (int a = 0; a < 8; a++) m_regs[a] = '0;
    m_ff = 1'b0; m_por = 1'b1; m_flt = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R8 reset state
    chk("R8 reset regs", regs_o, 96'h0);
    chk("R8 reset run", run_o, 1'b0);
    chk("R9 oe idle", miso_oe_o, 1'b0);

    // R6 power-up flag visible, R1 write commits
    do_frame("R1", {3'd0, 1'b1, 12'h5A5}, 16);
    do_frame("R1", {3'd3, 1'b1, 12'hC3C}, 16);
    // R5 readback
    do_frame("R5", {3'd0, 1'b0, 12'h000}, 16);
    do_frame("R5", {3'd3, 1'b0, 12'hFFF}, 16);

    // R2 short and long frames
    do_frame("R2 short", {3'd1, 1'b1, 12'h777}, 15);
    do_frame("R2 long", {3'd1, 1'b1, 12'h777}, 17);
    // R2 latches survive an error
    pulse_fault(12'h801);
    do_frame("R2 zero", 16'h0, 0);
    do_frame("R2 keep", {3'd1, 1'b0, 12'h0}, 16);
    // R3 clearing write
    do_frame("R3", {3'd2, 1'b1, 12'h123}, 16);
    do_frame("R3 after", {3'd2, 1'b0, 12'h0}, 16);

    // R7 mask
    do_frame("R7 mask", {3'd6, 1'b1, 12'h00F}, 16);
    pulse_fault(12'h0FF);
    do_frame("R7 status", {3'd5, 1'b1, 12'h0AA}, 16);
    do_frame("R7 unmask", {3'd6, 1'b1, 12'h000}, 16);

    // R9 activity with select high is ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) sclk_i = ~sclk_i; mosi_i = i[0];
      wait_clk(H);
      chk("R9 oe high select", miso_oe_o, 1'b0);
    end
    sclk_i = 1'b0; mosi_i = 1'b0;
    wait_clk(10);
    chk("R9 regs untouched", regs_o, exp_flat());
    do_frame("R9 status", {3'd4, 1'b0, 12'h0}, 16);

    // R8 run bit
    do_frame("R8 on", {3'd7, 1'b1, 12'h001}, 16);
    chk("R8 run set", run_o, 1'b1);
    do_frame("R8 off", {3'd7, 1'b1, 12'h000}, 16);
    chk("R8 run clear", run_o, 1'b0);

    // random mix
    for (int k = 0; k < 50; k++) begin
      logic [15:0] w;
      int n;
      w = 16'($urandom);
      n = ($urandom % 4 != 0) ? 16 : int'($urandom % 21);
      if ($urandom % 3 == 0) pulse_fault(12'($urandom));
      do_frame("R1 R2 R5 R7 random", w, n);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule